// File: doc/BRIEF.md
# Aggregate High Bit-Error-Rate Monitor

This block watches the 2-bit sync headers of the 66-bit block stream after all lanes have been locked, aligned and deskewed into one aggregate stream. A header of 00 or 11 is never legal, so each one seen on a valid block is counted as an error. The block counts these errors over a fixed time window. When the count for one window reaches a threshold (16 by default, which is close to a bit error ratio of 1e-4), it raises `hi_ber`.

The window length is a parameter given in clock-enable periods. The timer advances only on cycles where `tick` is high, so tying `tick` high makes the window a plain count of clock cycles. The flag rises on the cycle after the threshold is reached and does not wait for the window to close. It falls only at a window end, and only if the window that just closed stayed below the threshold.

While `align_done` is low, the monitor has no stream it can trust. It holds its counters cleared and forces `hi_ber` high. The reset is asynchronous and active low, and its release is synchronized inside the block.

Top module: `agg_hiber_mon`

## Requirements
- R1: On a cycle with `blk_vld` and `align_done` high, a header of 2'b00 or 2'b11 counts as exactly one error. Headers 2'b01 and 2'b10 count as none.
- R2: A header presented while `blk_vld` is low is never counted, whatever its value.
- R3: When the ERR_LIMIT-th error of a window arrives, `hi_ber` is high on the next cycle, even if the window has not ended.
- R4: Each window has its own error count. Errors from a window that has closed never add to the next window.
- R5: On the cycle after a window end, `hi_ber` is low if the window that just closed held fewer than ERR_LIMIT errors. It is high if that window reached the limit.
- R6: Apart from R5, R3 and R7, `hi_ber` holds its value from one cycle to the next.
- R7: While `align_done` is low, `hi_ber` is high on the next cycle and the window and error count are cleared. The first window starts on the first cycle with `align_done` high.
- R8: The window timer advances only on cycles with `tick` high. A window ends on the tick-qualified cycle that completes WIN_LEN ticks.
- R9: During reset, `hi_ber` is high and the window timer is at zero.
- R10: An error that arrives on the final cycle of a window is counted in that window, and it can raise `hi_ber`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_vld | input | 1 | A 66-bit block is present this cycle |
| sync_hdr | input | 2 | Sync header of the present block |
| align_done | input | 1 | All lanes locked, aligned and deskewed |
| tick | input | 1 | Window timer enable |
| hi_ber | output | 1 | High bit-error-rate flag |

## Verification
A window timer that is off by one count shows up at the port as a `hi_ber` fall one tick early or late, at the end of the first window after alignment. A miscounted or leaking error register shows up in the threshold sweep, where `hi_ber` rises one error early or late. It can also rise when errors straddle a window boundary. The bench follows the requirements with a cycle model of its own and compares `hi_ber` on every cycle, so any such fault is reported within one window of the stimulus that exposes it.

// File: rtl/ber_mon_pkg.sv
package ber_mon_pkg;
  typedef logic [1:0] sync_hdr_t;

  localparam sync_hdr_t HDR_DATA = 2'b01;
  localparam sync_hdr_t HDR_CTRL = 2'b10;

  // a header is legal only when its two bits differ
  function automatic logic hdr_is_bad(input sync_hdr_t h);
    return (h != HDR_DATA) && (h != HDR_CTRL);
  endfunction
endpackage

// File: rtl/ber_rst_sync.sv
module ber_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= {shreg_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = shreg_q[STAGES-1];
endmodule

// File: rtl/ber_hdr_check.sv
module ber_hdr_check
  import ber_mon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      blk_vld,
  input  sync_hdr_t sync_hdr,
  input  logic      align_done,
  output logic      err_pulse
);
  always_comb begin
    err_pulse = blk_vld && align_done && hdr_is_bad(sync_hdr);
  end

  // R2: an error can only come from a valid block on an aligned stream
  a_r2_err_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> (blk_vld && align_done));
endmodule

// File: rtl/ber_win_timer.sv
module ber_win_timer #(
  parameter int WIN_LEN = 20142
) (
  input  logic clk,
  input  logic rst_n,
  input  logic align_done,
  input  logic tick,
  output logic win_end
);
  localparam int PW = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
  localparam logic [PW-1:0] LAST_POS = PW'(WIN_LEN - 1);

  logic [PW-1:0] pos_q;
  logic [PW-1:0] pos_d;
  logic          pos_en;

  always_comb begin
    win_end = align_done && tick && (pos_q == LAST_POS);
    pos_en  = !align_done || tick;
    if (!align_done || win_end) pos_d = '0;
    else                        pos_d = pos_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  // R8: the window position never runs past the last count
  a_r8_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_POS);
  // R8: without a tick the position holds while aligned
  a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (align_done && !tick) |=> $stable(pos_q));
endmodule

// File: rtl/ber_err_count.sv
module ber_err_count #(
  parameter int ERR_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic align_done,
  input  logic err_pulse,
  input  logic win_end,
  output logic thresh_hit
);
  localparam int CW = $clog2(ERR_LIMIT + 1);
  localparam logic [CW:0]   LIMIT_W = (CW + 1)'(ERR_LIMIT);
  localparam logic [CW-1:0] LIMIT_C = CW'(ERR_LIMIT);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW:0]   cnt_total;

  always_comb begin
    cnt_total  = {1'b0, cnt_q} + {{CW{1'b0}}, err_pulse};
    thresh_hit = align_done && (cnt_total >= LIMIT_W);
    if (!align_done || win_end) cnt_d = '0;
    else if (thresh_hit)        cnt_d = LIMIT_C;
    else                        cnt_d = cnt_total[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3: the count saturates at the limit and never wraps
  a_r3_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT_C);
  // R4: a window end leaves no errors behind for the next window
  a_r4_clear_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (cnt_q == '0));
endmodule

// File: rtl/agg_hiber_mon.sv
module agg_hiber_mon
  import ber_mon_pkg::*;
#(
  parameter int WIN_LEN   = 20142,
  parameter int ERR_LIMIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       blk_vld,
  input  logic [1:0] sync_hdr,
  input  logic       align_done,
  input  logic       tick,
  output logic       hi_ber
);
  logic rst_sync_n;
  logic err_pulse;
  logic win_end;
  logic thresh_hit;
  logic hi_ber_d;

  ber_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ber_hdr_check u_hdr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .blk_vld    (blk_vld),
    .sync_hdr   (sync_hdr),
    .align_done (align_done),
    .err_pulse  (err_pulse)
  );

  ber_win_timer #(.WIN_LEN(WIN_LEN)) u_timer (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .align_done (align_done),
    .tick       (tick),
    .win_end    (win_end)
  );

  ber_err_count #(.ERR_LIMIT(ERR_LIMIT)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .align_done (align_done),
    .err_pulse  (err_pulse),
    .win_end    (win_end),
    .thresh_hit (thresh_hit)
  );

  always_comb begin
    if (!align_done)     hi_ber_d = 1'b1;
    else if (thresh_hit) hi_ber_d = 1'b1;
    else if (win_end)    hi_ber_d = 1'b0;
    else                 hi_ber_d = hi_ber;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) hi_ber <= 1'b1;
    else             hi_ber <= hi_ber_d;
  end

  // R7: losing alignment forces the flag high
  a_r7_forced_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !align_done |=> hi_ber);
  // R5/R6: the flag only falls right after a window end
  a_r6_fall_at_end: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(hi_ber) |-> $past(win_end));
  // R3: reaching the limit always leaves the flag high
  a_r3_rise_on_limit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    thresh_hit |=> hi_ber);
endmodule

// File: tb/agg_hiber_mon_test.sv
module agg_hiber_mon_test;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 24;
  localparam int LIM = 6;

  logic       clk;
  logic       rst_n;
  logic       blk_vld;
  logic [1:0] sync_hdr;
  logic       align_done;
  logic       tick;
  logic       hi_ber;

  int total = 0;
  int bad   = 0;

  // requirement-level model state
  int m_pos = 0;
  int m_err = 0;
  logic m_flag = 1'b1;

  agg_hiber_mon #(.WIN_LEN(WIN), .ERR_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .blk_vld(blk_vld), .sync_hdr(sync_hdr),
    .align_done(align_done), .tick(tick), .hi_ber(hi_ber)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic exp, input string tag);
    total++;
    if (hi_ber !== exp) begin
      bad++;
      $display("FAIL %s: hi_ber=%b expected=%b at %0t", tag, hi_ber, exp, $time);
    end
  endtask

  // drive one cycle from a negedge, update the model at the edge, check at the next negedge
  task automatic step(input logic v, input logic [1:0] h, input logic t,
                      input logic a, input string tag);
    int e;
    int tot;
    logic last;
    blk_vld = v; sync_hdr = h; tick = t; align_done = a;
    @(posedge clk);
    if (!a) begin
      m_flag = 1'b1; m_pos = 0; m_err = 0;
    end else begin
      e    = (v && (h == 2'b00 || h == 2'b11)) ? 1 : 0;
      tot  = m_err + e;
      last = t && (m_pos == WIN - 1);
      if (tot >= LIM) m_flag = 1'b1;
      else if (last)  m_flag = 1'b0;
      if (last) begin
        m_pos = 0; m_err = 0;
      end else begin
        if (t) m_pos++;
        m_err = (tot > LIM) ? LIM : tot;
      end
    end
    @(negedge clk);
    check(m_flag, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; blk_vld = 1'b0; sync_hdr = 2'b01; align_done = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    check(1'b1, "R9 reset flag");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 2'b00, 1'b1, 1'b0, "R7/R9 unaligned after reset");

    // clean stream: the first window closes and clears the flag
    for (int i = 0; i < WIN + 4; i++) step(1'b1, 2'b01, 1'b1, 1'b1, "R5 clean window");

    // sweep error counts, mixing bad, invalid-but-bad and good headers
    for (int n = 0; n <= LIM + 2; n++) begin
      step(1'b1, 2'b01, 1'b1, 1'b0, "R7 realign");
      for (int i = 0; i < 3 * WIN; i++) begin
        if (i % 3 == 0 && i / 3 < n)
          step(1'b1, (i % 2 == 0) ? 2'b00 : 2'b11, 1'b1, 1'b1, "R1/R3 threshold sweep");
        else if (i % 3 == 1)
          step(1'b0, 2'b11, 1'b1, 1'b1, "R2 invalid block ignored");
        else
          step(1'b1, (i % 2 == 0) ? 2'b10 : 2'b01, 1'b1, 1'b1, "R1 good header");
      end
    end

    // errors straddling a window boundary must not add up
    step(1'b1, 2'b01, 1'b1, 1'b0, "R7 realign");
    for (int i = 0; i < 2 * WIN; i++)
      step(1'b1, (i >= WIN - LIM + 1 && i < WIN + LIM - 1) ? 2'b00 : 2'b01,
           1'b1, 1'b1, "R4 straddle");
    for (int i = 0; i < WIN; i++) step(1'b1, 2'b01, 1'b1, 1'b1, "R4 straddle tail");

    // sparse tick stretches the window
    for (int i = 0; i < 4 * WIN; i++)
      step(1'b1, (i % 7 == 0) ? 2'b11 : 2'b10, (i % 3 == 0), 1'b1, "R8 tick gating");
    for (int i = 0; i < 3 * WIN; i++)
      step(1'b1, (i < LIM) ? 2'b00 : 2'b01, (i % 3 == 0), 1'b1, "R8 tick burst");

    // limit reached on the final cycle of a window
    step(1'b1, 2'b01, 1'b1, 1'b0, "R7 realign");
    for (int i = 0; i < WIN; i++)
      step(1'b1, (i < LIM - 1 || i == WIN - 1) ? 2'b11 : 2'b01, 1'b1, 1'b1,
           "R10 last-cycle error");
    check(1'b1, "R10 flag after last-cycle limit");
    for (int i = 0; i < WIN; i++) step(1'b1, 2'b01, 1'b1, 1'b1, "R6 hold then R5 clear");
    check(1'b0, "R5 clear after clean window");

    // alignment loss mid-window while the flag is low
    for (int i = 0; i < WIN / 2; i++) step(1'b1, 2'b01, 1'b1, 1'b1, "R6 hold low");
    step(1'b1, 2'b01, 1'b1, 1'b0, "R7 alignment lost");
    check(1'b1, "R7 forced high");
    for (int i = 0; i < WIN + 2; i++) step(1'b1, 2'b01, 1'b1, 1'b1, "R7 fresh window");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule